// File: doc/BRIEF.md
# Dual-Doorbell Mailbox Register File

This block is the register file through which a host processor and an on-chip service engine trade fixed-size packets. The host fills four 64-bit command words and rings the engine doorbell. The engine places its reply in four 64-bit response words and rings the host doorbell. Each side has its own simple register port: a word address, a write enable and 64-bit write data, with registered read data one cycle later. Either port can read every register.

Each doorbell is reachable at three adjacent addresses. One replaces the whole value. One ANDs the write data into the stored value, so a caller can clear selected bits without disturbing the rest. One ORs the write data in, so a caller can set selected bits. Bits are numbered MSB-first, so bit 0 is data bit 63. The engine sees an interrupt while its "message waiting" bit is set. The host sees an interrupt while any event bit of its doorbell that belongs to the interrupt mask is set. The host is expected to clear its doorbell once it has consumed a response.

Top module: `mbox_regfile`

## Requirements
- R1: After a synchronous reset, every command word, response word and doorbell holds zero, both interrupts are low and both read-data outputs are zero.
- R2: A host write to word address 0x50+i (i = 0..3) stores the data in command word i. A read of that address from either port returns it on the read-data output one clock after the address is presented.
- R3: An engine write to word address 0x54+i (i = 0..3) stores the data in response word i, and it reads back in the same way.
- R4: An engine write to a command address and a host write to a response address are ignored, and the stored word keeps its value.
- R5: A write to 0x60 (engine doorbell) or 0x63 (host doorbell) replaces the doorbell value. A read at any of a doorbell's three addresses returns its current value.
- R6: A write to 0x61 or 0x64 stores the old doorbell value ANDed with the write data.
- R7: A write to 0x62 or 0x65 stores the old doorbell value ORed with the write data.
- R8: When both ports write the same doorbell in one cycle, a replace from the host wins over a replace from the engine. All OR data is then applied, and all AND data is applied after that.
- R9: host_irq is high exactly while the host doorbell has one of MSB-first bits 0, 1, 2, 3, 4 or 14 set (data bits 63..59 and 49, mask 64'hF802_0000_0000_0000). Other bits never raise it.
- R10: eng_irq is high exactly while MSB-first bit 0 (data bit 63) of the engine doorbell is set.
- R11: An address outside 0x50..0x57 and 0x60..0x65 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host word address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| host_irq | output | 1 | Response interrupt toward the host |
| eng_addr | input | ADDR_W | Engine word address |
| eng_we | input | 1 | Engine write enable |
| eng_wdata | input | 64 | Engine write data |
| eng_rdata | output | 64 | Engine read data, registered |
| eng_irq | output | 1 | Message-waiting interrupt toward the engine |

## Verification
On every cycle, the assertions check the following:
- Each interrupt agrees with its doorbell contents, whatever mix of accesses produced them.
- The command bank never moves without a host write, and the response bank never moves without an engine write.
- A lone OR access leaves all of its bits set, and a lone AND access leaves all of its zero bits cleared.

Only the bench scenarios can show the rest:
- The actual values after a merged same-cycle access, where the order of replace, OR and AND decides the result.
- The read-back through every alias address.
- The silence of unmapped addresses.
- The boundary between mask bits and neighbouring non-mask bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW = 64;

  typedef enum logic [1:0] {AL_RW = 2'd0, AL_AND = 2'd1, AL_OR = 2'd2} alias_e;

  typedef enum logic [2:0] {SEL_NONE, SEL_CMD, SEL_RSP, SEL_EDB, SEL_HDB} sel_e;

  typedef struct packed {
    logic          en;
    alias_e        al;
    logic [DW-1:0] data;
  } db_op_t;

  // MSB-first bits 0..4 and 14 of the host doorbell
  localparam logic [DW-1:0] HOST_IRQ_MASK = 64'hF802_0000_0000_0000;
  // MSB-first bit 0 of the engine doorbell
  localparam logic [DW-1:0] ENG_IRQ_MASK  = 64'h8000_0000_0000_0000;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NWORDS   = 4,
  parameter int CMD_BASE = 'h50,
  parameter int EDB_BASE = 'h60,
  parameter int HDB_BASE = 'h63,
  localparam int IW      = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output sel_e              sel,
  output logic [IW-1:0]     idx,
  output db_op_t            edb_op,
  output db_op_t            hdb_op
);
  localparam logic [ADDR_W-1:0] CMD_LO = ADDR_W'(CMD_BASE);
  localparam logic [ADDR_W-1:0] RSP_LO = ADDR_W'(CMD_BASE + NWORDS);
  localparam logic [ADDR_W-1:0] RSP_HI = ADDR_W'(CMD_BASE + 2 * NWORDS);
  localparam logic [ADDR_W-1:0] EDB_LO = ADDR_W'(EDB_BASE);
  localparam logic [ADDR_W-1:0] EDB_HI = ADDR_W'(EDB_BASE + 3);
  localparam logic [ADDR_W-1:0] HDB_LO = ADDR_W'(HDB_BASE);
  localparam logic [ADDR_W-1:0] HDB_HI = ADDR_W'(HDB_BASE + 3);

  logic [ADDR_W-1:0] off;
  alias_e            al;

  always_comb begin
    sel = SEL_NONE;
    off = '0;
    if (addr >= CMD_LO && addr < RSP_LO) begin
      sel = SEL_CMD;
      off = addr - CMD_LO;
    end else if (addr >= RSP_LO && addr < RSP_HI) begin
      sel = SEL_RSP;
      off = addr - RSP_LO;
    end else if (addr >= EDB_LO && addr < EDB_HI) begin
      sel = SEL_EDB;
      off = addr - EDB_LO;
    end else if (addr >= HDB_LO && addr < HDB_HI) begin
      sel = SEL_HDB;
      off = addr - HDB_LO;
    end
    idx = off[IW-1:0];
    al  = alias_e'(off[1:0]);
  end

  always_comb begin
    edb_op.en   = we && (sel == SEL_EDB);
    edb_op.al   = al;
    edb_op.data = wdata;
    hdb_op.en   = we && (sel == SEL_HDB);
    hdb_op.al   = al;
    hdb_op.data = wdata;
  end
endmodule

// File: rtl/mbox_wordbank.sv
module mbox_wordbank
  import mbox_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [DW-1:0]             wdata,
  output logic [NWORDS-1:0][DW-1:0] words
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                              words[g] <= '0;
      else if (we && widx == IW'(g))        words[g] <= wdata;
    end
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter logic [DW-1:0] IRQ_MASK = HOST_IRQ_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  db_op_t        hop,
  input  db_op_t        eop,
  output logic [DW-1:0] q,
  output logic          irq
);
  logic [DW-1:0] base, or_bits, and_bits, nxt;

  always_comb begin
    base = q;
    if (eop.en && eop.al == AL_RW) base = eop.data;
    if (hop.en && hop.al == AL_RW) base = hop.data;
    or_bits  = '0;
    and_bits = '1;
    if (hop.en && hop.al == AL_OR)  or_bits  = or_bits  | hop.data;
    if (eop.en && eop.al == AL_OR)  or_bits  = or_bits  | eop.data;
    if (hop.en && hop.al == AL_AND) and_bits = and_bits & hop.data;
    if (eop.en && eop.al == AL_AND) and_bits = and_bits & eop.data;
    nxt = (base | or_bits) & and_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      irq <= 1'b0;
    end else begin
      q   <= nxt;
      irq <= |(nxt & IRQ_MASK);
    end
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NWORDS   = 4,
  parameter int CMD_BASE = 'h50,
  parameter int EDB_BASE = 'h60,
  parameter int HDB_BASE = 'h63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              host_irq,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic              eng_we,
  input  logic [63:0]       eng_wdata,
  output logic [63:0]       eng_rdata,
  output logic              eng_irq
);
  localparam int IW = $clog2(NWORDS);

  sel_e                      h_sel, e_sel;
  logic [IW-1:0]             h_idx, e_idx;
  db_op_t                    h_edb, h_hdb, e_edb, e_hdb;
  logic [NWORDS-1:0][DW-1:0] cmd_words, rsp_words;
  logic [DW-1:0]             edb_q, hdb_q;

  mbox_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .CMD_BASE(CMD_BASE),
                .EDB_BASE(EDB_BASE), .HDB_BASE(HDB_BASE)) u_dec_host (
    .addr(host_addr), .we(host_we), .wdata(host_wdata),
    .sel(h_sel), .idx(h_idx), .edb_op(h_edb), .hdb_op(h_hdb));

  mbox_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .CMD_BASE(CMD_BASE),
                .EDB_BASE(EDB_BASE), .HDB_BASE(HDB_BASE)) u_dec_eng (
    .addr(eng_addr), .we(eng_we), .wdata(eng_wdata),
    .sel(e_sel), .idx(e_idx), .edb_op(e_edb), .hdb_op(e_hdb));

  // Command bank: host port is the only writer
  mbox_wordbank #(.NWORDS(NWORDS)) u_cmd (
    .clk(clk), .rst(rst), .we(host_we && h_sel == SEL_CMD),
    .widx(h_idx), .wdata(host_wdata), .words(cmd_words));

  // Response bank: engine port is the only writer
  mbox_wordbank #(.NWORDS(NWORDS)) u_rsp (
    .clk(clk), .rst(rst), .we(eng_we && e_sel == SEL_RSP),
    .widx(e_idx), .wdata(eng_wdata), .words(rsp_words));

  mbox_doorbell #(.IRQ_MASK(ENG_IRQ_MASK)) u_edb (
    .clk(clk), .rst(rst), .hop(h_edb), .eop(e_edb), .q(edb_q), .irq(eng_irq));

  mbox_doorbell #(.IRQ_MASK(HOST_IRQ_MASK)) u_hdb (
    .clk(clk), .rst(rst), .hop(h_hdb), .eop(e_hdb), .q(hdb_q), .irq(host_irq));

  function automatic logic [DW-1:0] rd_mux(input sel_e s, input logic [IW-1:0] i);
    case (s)
      SEL_CMD: return cmd_words[i];
      SEL_RSP: return rsp_words[i];
      SEL_EDB: return edb_q;
      SEL_HDB: return hdb_q;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      eng_rdata  <= '0;
    end else begin
      host_rdata <= rd_mux(h_sel, h_idx);
      eng_rdata  <= rd_mux(e_sel, e_idx);
    end
  end
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NWORDS   = 4,
  parameter int HDB_BASE = 'h63
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         host_addr,
  input logic                      host_we,
  input logic [63:0]               host_wdata,
  input logic                      eng_we,
  input logic                      host_irq,
  input logic                      eng_irq,
  input logic [NWORDS-1:0][DW-1:0] cmd_words,
  input logic [NWORDS-1:0][DW-1:0] rsp_words,
  input logic [DW-1:0]             edb_q,
  input logic [DW-1:0]             hdb_q
);
  localparam logic [ADDR_W-1:0] HDB_AND = ADDR_W'(HDB_BASE + 1);
  localparam logic [ADDR_W-1:0] HDB_OR  = ADDR_W'(HDB_BASE + 2);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!host_irq && !eng_irq)); // R1

  AST_CMD_HOST_ONLY: assert property (@(posedge clk) disable iff (rst)
    !host_we |=> $stable(cmd_words)); // R4

  AST_RSP_ENG_ONLY: assert property (@(posedge clk) disable iff (rst)
    !eng_we |=> $stable(rsp_words)); // R4

  AST_OR_SETS: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == HDB_OR && !eng_we)
      |=> ((hdb_q & $past(host_wdata)) == $past(host_wdata))); // R7

  AST_AND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == HDB_AND && !eng_we)
      |=> ((hdb_q & ~$past(host_wdata)) == '0)); // R6

  AST_HOST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    host_irq == ((hdb_q & HOST_IRQ_MASK) != '0)); // R9

  AST_ENG_IRQ_BIT: assert property (@(posedge clk) disable iff (rst)
    eng_irq == edb_q[DW-1]); // R10
endmodule

bind mbox_regfile mbox_regfile_chk #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .HDB_BASE(HDB_BASE)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
  .eng_we(eng_we), .host_irq(host_irq), .eng_irq(eng_irq),
  .cmd_words(cmd_words), .rsp_words(rsp_words), .edb_q(edb_q), .hdb_q(hdb_q));

// File: tb/mbox_regfile_bench.sv
`timescale 1ns/1ps
module mbox_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_addr = '0, eng_addr = '0;
  logic        host_we = 1'b0, eng_we = 1'b0;
  logic [63:0] host_wdata = '0, eng_wdata = '0;
  logic [63:0] host_rdata, eng_rdata;
  logic        host_irq, eng_irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbox_regfile u_mbox_regfile (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata), .eng_irq(eng_irq));

  // {req, side (0 host / 1 engine), addr, wdata, expected host read-back}
  localparam int NV = 13;
  localparam logic [140:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h50, 64'hA5A5_0000_1111_2222, 64'hA5A5_0000_1111_2222}, // R2
    {4'd2,  1'b0, 8'h53, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0}, // R2
    {4'd3,  1'b1, 8'h54, 64'h00C0_FFEE_0000_0001, 64'h00C0_FFEE_0000_0001}, // R3
    {4'd3,  1'b1, 8'h57, 64'hDEAD_BEEF_0000_0007, 64'hDEAD_BEEF_0000_0007}, // R3
    {4'd4,  1'b1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_0000_1111_2222}, // R4
    {4'd4,  1'b0, 8'h57, 64'h0000_0000_0000_0000, 64'hDEAD_BEEF_0000_0007}, // R4
    {4'd5,  1'b0, 8'h60, 64'h8000_0000_0000_00F0, 64'h8000_0000_0000_00F0}, // R5
    {4'd7,  1'b0, 8'h62, 64'h0000_0000_0000_000F, 64'h8000_0000_0000_00FF}, // R7
    {4'd6,  1'b0, 8'h61, 64'h8000_0000_0000_000F, 64'h8000_0000_0000_000F}, // R6
    {4'd5,  1'b1, 8'h63, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001}, // R5
    {4'd7,  1'b1, 8'h65, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001}, // R7
    {4'd6,  1'b0, 8'h64, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001}, // R6
    {4'd11, 1'b0, 8'h70, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}  // R11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic side, input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    if (side) begin eng_we = 1'b1; eng_addr = a; eng_wdata = d; end
    else      begin host_we = 1'b1; host_addr = a; host_wdata = d; end
    @(negedge clk);
    host_we = 1'b0; eng_we = 1'b0;
  endtask

  task automatic wr_both(input logic [7:0] ha, input logic [63:0] hd,
                         input logic [7:0] ea, input logic [63:0] ed);
    @(negedge clk);
    host_we = 1'b1; host_addr = ha; host_wdata = hd;
    eng_we  = 1'b1; eng_addr  = ea; eng_wdata  = ed;
    @(negedge clk);
    host_we = 1'b0; eng_we = 1'b0;
  endtask

  task automatic rd_host(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
  endtask

  task automatic rd_eng(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    eng_we = 1'b0; eng_addr = a;
    @(posedge clk); #1;
    d = eng_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    check("R1 host_rdata", host_rdata, '0);
    check("R1 eng_rdata", eng_rdata, '0);
    check("R1 irqs", {62'd0, host_irq, eng_irq}, '0);
    rd_host(8'h50, r); check("R1 cmd0", r, '0);
    rd_host(8'h63, r); check("R1 host doorbell", r, '0);

    for (int i = 0; i < NV; i++) begin
      logic [140:0] v;
      v = VEC[i];
      wr(v[136], v[135:128], v[127:64]);
      rd_host(v[135:128], r);
      checks++;
      if (r !== v[63:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", v[140:137], i, r, v[63:0]);
      end
    end

    // R2: engine port reads command word
    rd_eng(8'h53, r); check("R2 engine read cmd3", r, 64'h1234_5678_9ABC_DEF0);
    // R5: every alias reads current engine doorbell
    rd_eng(8'h61, r); check("R5 alias and-read", r, 64'h8000_0000_0000_000F);
    rd_host(8'h62, r); check("R5 alias or-read", r, 64'h8000_0000_0000_000F);
    // R11: unmapped write touched nothing
    rd_host(8'h50, r); check("R11 cmd0 intact", r, 64'hA5A5_0000_1111_2222);

    // R10: engine interrupt follows MSB-first bit 0 only
    #1; check("R10 eng_irq set", {63'd0, eng_irq}, 64'd1);
    wr(1'b0, 8'h60, 64'h0000_0000_0000_0001); #1;
    check("R10 eng_irq low bit only", {63'd0, eng_irq}, 64'd0);
    wr(1'b0, 8'h62, 64'h8000_0000_0000_0000); #1;
    check("R10 eng_irq after or", {63'd0, eng_irq}, 64'd1);
    wr(1'b1, 8'h61, 64'h7FFF_FFFF_FFFF_FFFF); #1;
    check("R10 eng_irq cleared", {63'd0, eng_irq}, 64'd0);

    // R9: host interrupt mask boundaries
    wr(1'b1, 8'h63, 64'h0001_0000_0000_0000); #1;
    check("R9 bit15 no irq", {63'd0, host_irq}, 64'd0);
    wr(1'b1, 8'h65, 64'h0002_0000_0000_0000); #1;
    check("R9 bit14 irq", {63'd0, host_irq}, 64'd1);
    wr(1'b1, 8'h63, 64'h0800_0000_0000_0000); #1;
    check("R9 bit4 irq", {63'd0, host_irq}, 64'd1);
    wr(1'b1, 8'h63, 64'h0400_0000_0000_0000); #1;
    check("R9 bit5 no irq", {63'd0, host_irq}, 64'd0);
    wr(1'b1, 8'h63, 64'h8000_0000_0000_0000); #1;
    check("R9 bit0 irq", {63'd0, host_irq}, 64'd1);
    wr(1'b0, 8'h63, 64'h0); #1;
    check("R9 host clears", {63'd0, host_irq}, 64'd0);

    // R8: same-cycle merges on the host doorbell
    wr(1'b1, 8'h63, 64'h0F);
    wr_both(8'h65, 64'hF0, 8'h64, 64'h3C);
    rd_host(8'h63, r); check("R8 or then and", r, 64'h3C);
    wr_both(8'h63, 64'h11, 8'h63, 64'h22);
    rd_host(8'h63, r); check("R8 host replace wins", r, 64'h11);
    wr_both(8'h63, 64'h11, 8'h65, 64'h100);
    rd_host(8'h63, r); check("R8 replace plus or", r, 64'h111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule